// File: doc/BRIEF.md
# CRC-Protected SPI Register Port

This block is a configuration and status port reached through its own SPI chip select. A host sends a command byte and one data byte in each transfer, and may add a CRC-8 byte to protect it. Behind the port is a small register file. It holds a configuration byte, a read-only status byte taken from input pins, a set of event flags that software clears by writing zero, interrupt enables, a set of sticky fault flags, a word-length setting and a scratch byte.

The SPI pins are sampled by the block's system clock, so SCK must be slow compared with that clock. A write reaches the registers only when the chip select is released, and only if the frame is whole: either exactly two bytes, or three bytes whose last byte is the correct CRC. Any other write frame is discarded and raises a write fault. The block drives one active-low interrupt. It is the AND of the local interrupt (an event that is enabled) and an external remote interrupt line.

Top module: `regp_spi_regport`

## Requirements
- R1: After reset, config reads 0x00, word length reads 0x08, scratch reads 0x00, and the events, enables and faults all read 0x00. `irq_n` then follows `remote_irq_n`.
- R2: SPI mode (0,0) and mode (1,1) both work. The block captures MOSI on the rising SCK edge and changes MISO on the falling edge. Every byte is sent MSB first. MISO is 0 during the command byte.
- R3: The command byte holds the register address in bits [7:1]. Bit 0 sets the direction: 1 is a read, 0 is a write. The register addresses are config 0x00, status 0x01, events 0x02, enables 0x03, faults 0x04, word length 0x05 and scratch 0x06.
- R4: A write frame of exactly two whole bytes updates the addressed register when the chip select is released.
- R5: A write frame of three whole bytes is committed only when the third byte equals CRC-8 over the command byte and then the data byte. The CRC uses polynomial 0x07, initial value 0x00, and processes bits MSB first.
- R6: The following write frames are discarded, and each sets fault bit 0 and event bit 2: a frame that ends after the command byte, a frame that ends part-way through a byte, a frame with a wrong CRC, and a frame longer than three bytes. A read that ends part-way through a byte has no effect.
- R7: In a read, MISO carries the register value as the second byte. The third byte is the CRC-8 over the command byte and that value.
- R8: Writes to status (0x01), to faults (0x04) and to unmapped addresses are ignored. Reads of unmapped addresses return 0x00. Status reads return `status_in`.
- R9: A pulse on `link_up_pulse` sets event bit 0 and a pulse on `link_down_pulse` sets event bit 1. Writing 0 to an event bit clears it. Writing 1 leaves it unchanged.
- R10: A pulse on `fault_pulse[k]` sets fault bit k+1. Any new fault sets event bit 2. Writing 0 to event bit 2 also clears every fault bit.
- R11: `irq_n` is low when any event bit and its matching enable bit (enables 0x03, bits [2:0]) are both 1, or when `remote_irq_n` is low. Otherwise it is high.
- R12: A word-length write below 8 is stored as 8, and a write above 32 is stored as 32. Values from 8 to 32 are stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it also oversamples the SPI pins |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Chip select of the register port, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| status_in | input | 8 | Live status byte shown at address 0x01 |
| link_up_pulse | input | 1 | One-cycle pulse that sets event bit 0 |
| link_down_pulse | input | 1 | One-cycle pulse that sets event bit 1 |
| fault_pulse | input | 4 | One-cycle pulses that set fault bits 1 to 4 |
| remote_irq_n | input | 1 | Remote interrupt, active low |
| cfg_o | output | 8 | Contents of the config register |
| word_len_o | output | 8 | Word length after clamping |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The assertions assume that each SCK level and each chip-select level lasts several system clocks. Under that assumption, the synchronised edges come well apart and the select is still high in the cycle after the frame closes. They also assume that MOSI is stable around each rising SCK edge. The stimulus meets this with half periods of eight clocks and gaps of twelve clocks between frames. It changes MOSI only together with the falling edge or before the first rising edge, and it holds each pulse input high for exactly one clock.

// File: rtl/regp_pkg.sv
// Package regp_pkg
// Holds the shared register addresses, the event bit positions, the write
// request type and the CRC-8 step used by the register port.
// Assumes 8-bit bytes on the serial side.
package regp_pkg;

    localparam logic [6:0] A_CFG  = 7'h00;
    localparam logic [6:0] A_STAT = 7'h01;
    localparam logic [6:0] A_EVT  = 7'h02;
    localparam logic [6:0] A_IEN  = 7'h03;
    localparam logic [6:0] A_FLT  = 7'h04;
    localparam logic [6:0] A_WLEN = 7'h05;
    localparam logic [6:0] A_SCR  = 7'h06;

    localparam int EV_UP   = 0;
    localparam int EV_DOWN = 1;
    localparam int EV_FLT  = 2;
    localparam int EV_W    = 3;

    localparam logic [7:0] CRC_POLY = 8'h07;

    typedef struct packed {
        logic       en;
        logic [6:0] addr;
        logic [7:0] data;
    } wr_req_t;

    // Folds one byte into a CRC-8, taking the MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] d);
        logic [7:0] c;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else             c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/regp_sync.sv
// Module regp_sync
// A chain of flip-flops that brings asynchronous pins into the clock domain.
// Assumes each pin holds its level for longer than STAGES clock cycles.
module regp_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Moves the sampled value one stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)     st[g] <= RST_VAL;
            else if (g == 0) st[g] <= d;
            else             st[g] <= st[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/regp_spi_engine.sv
// Module regp_spi_engine
// Serial engine for SPI modes (0,0) and (1,1). It captures MOSI on rising SCK
// and changes MISO on falling SCK, MSB first. It latches the command, data and
// CRC bytes, serves read data and the read CRC, and decides at select release
// whether a write frame is committed or counted as a fault.
// Assumes synchronised inputs and SCK half periods of several clock cycles.
module regp_spi_engine
    import regp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       mosi_s,
    input  logic       csn_s,
    input  logic [7:0] rd_data,
    output logic [6:0] rd_addr,
    output logic       miso,
    output wr_req_t    wr_req,
    output logic       wr_fault
);
    localparam logic [2:0] BYTE_SAT = 3'd4;

    logic       sck_d, csn_d;
    logic [2:0] bit_cnt, byte_cnt;
    logic [6:0] sr;
    logic [7:0] cmd_q, data_q, crc_rx_q, rdat_q, rcrc_q;
    logic       rd_load;
    logic [7:0] rx_byte, tx_cur, crc_exp;
    logic       sck_rise, sck_fall, cs_open, cs_close, is_rd;

    assign sck_rise = ~csn_s & sck_s & ~sck_d;
    assign sck_fall = ~csn_s & ~sck_s & sck_d;
    assign cs_open  = csn_d & ~csn_s;
    assign cs_close = ~csn_d & csn_s;
    assign rx_byte  = {sr, mosi_s};
    assign is_rd    = cmd_q[0];
    assign rd_addr  = cmd_q[7:1];
    assign crc_exp  = crc8_step(crc8_step(8'h00, cmd_q), data_q);

    // Picks the byte that MISO shifts out in the current byte slot.
    always_comb begin
        case (byte_cnt)
            3'd1:    tx_cur = is_rd ? rdat_q : 8'h00;
            3'd2:    tx_cur = is_rd ? rcrc_q : 8'h00;
            default: tx_cur = 8'h00;
        endcase
    end

    // Keeps the previous SCK and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    // Shifts in MOSI and files each completed byte into its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
            sr       <= '0;
            cmd_q    <= '0;
            data_q   <= '0;
            crc_rx_q <= '0;
        end else if (cs_open) begin
            bit_cnt  <= '0;
            byte_cnt <= '0;
        end else if (sck_rise) begin
            sr      <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
                if (byte_cnt != BYTE_SAT) byte_cnt <= byte_cnt + 3'd1;
                case (byte_cnt)
                    3'd0:    cmd_q    <= rx_byte;
                    3'd1:    data_q   <= rx_byte;
                    3'd2:    crc_rx_q <= rx_byte;
                    default: ;
                endcase
            end
        end
    end

    // Latches the read value and its CRC one cycle after the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_load <= 1'b0;
            rdat_q  <= '0;
            rcrc_q  <= '0;
        end else begin
            rd_load <= sck_rise && (bit_cnt == 3'd7) && (byte_cnt == 3'd0);
            if (rd_load) begin
                rdat_q <= rd_data;
                rcrc_q <= crc8_step(crc8_step(8'h00, cmd_q), rd_data);
            end
        end
    end

    // Changes MISO on falling SCK to the next bit of the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n)        miso <= 1'b0;
        else if (cs_open)  miso <= 1'b0;
        else if (sck_fall) miso <= tx_cur[~bit_cnt];
    end

    // At select release, commits a whole, valid write frame or flags a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_req   <= '0;
            wr_fault <= 1'b0;
        end else begin
            wr_req.en <= 1'b0;
            wr_fault  <= 1'b0;
            if (cs_close && (byte_cnt != 3'd0) && !is_rd) begin
                wr_req.addr <= cmd_q[7:1];
                wr_req.data <= data_q;
                if ((bit_cnt == 3'd0) &&
                    ((byte_cnt == 3'd2) || ((byte_cnt == 3'd3) && (crc_rx_q == crc_exp))))
                    wr_req.en <= 1'b1;
                else
                    wr_fault  <= 1'b1;
            end
        end
    end

    // R4: a committed write is a single pulse for its frame.
    p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req.en |=> !wr_req.en && !wr_fault);

    // R6: commit and fault decisions happen only while the select is released.
    p_decide_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req.en || wr_fault) |-> csn_s);

    // R2: MISO never changes while the select is released.
    p_miso_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |-> $stable(miso));

endmodule

// File: rtl/regp_regfile.sv
// Module regp_regfile
// Register file behind the serial port: config, status, events that are
// cleared by writing zero, interrupt enables, sticky faults, a clamped word
// length and scratch. It also forms the combined active-low interrupt.
// Assumes pulse inputs last one cycle and write requests are single pulses.
module regp_regfile
    import regp_pkg::*;
#(
    parameter int NX       = 4,
    parameter int WLEN_MIN = 8,
    parameter int WLEN_MAX = 32,
    parameter int WLEN_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_req_t       wr_req,
    input  logic          wr_fault,
    input  logic [6:0]    rd_addr,
    output logic [7:0]    rd_data,
    input  logic [7:0]    status_in,
    input  logic          link_up,
    input  logic          link_down,
    input  logic [NX-1:0] ext_flt,
    input  logic          remote_irq_n,
    output logic [7:0]    cfg_o,
    output logic [7:0]    wlen_o,
    output logic          irq_n
);
    localparam int NF = NX + 1;

    logic [7:0]      cfg_q, wlen_q, scr_q;
    logic [EV_W-1:0] ev_q, ien_q, ev_keep, ev_set;
    logic [NF-1:0]   flt_q, flt_new;
    logic            flt_wipe, hit_evt;

    // Keeps a requested word length inside the supported range.
    function automatic logic [7:0] clamp_len(input logic [7:0] v);
        if (v < 8'(WLEN_MIN))      return 8'(WLEN_MIN);
        else if (v > 8'(WLEN_MAX)) return 8'(WLEN_MAX);
        else                       return v;
    endfunction

    assign hit_evt  = wr_req.en && (wr_req.addr == A_EVT);
    assign ev_keep  = hit_evt ? wr_req.data[EV_W-1:0] : '1;
    assign flt_new  = {ext_flt, wr_fault};
    assign ev_set   = {|flt_new, link_down, link_up};
    assign flt_wipe = hit_evt && !wr_req.data[EV_FLT];

    // Updates the plain read/write registers from committed writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= 8'h00;
            wlen_q <= 8'(WLEN_RST);
            scr_q  <= 8'h00;
            ien_q  <= '0;
        end else if (wr_req.en) begin
            case (wr_req.addr)
                A_CFG:   cfg_q  <= wr_req.data;
                A_WLEN:  wlen_q <= clamp_len(wr_req.data);
                A_SCR:   scr_q  <= wr_req.data;
                A_IEN:   ien_q  <= wr_req.data[EV_W-1:0];
                default: ;
            endcase
        end
    end

    // Sets events from pulses and clears those written as zero; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ev_keep) | ev_set;
    end

    // Holds faults until the fault event is cleared; new faults win.
    always_ff @(posedge clk) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= (flt_wipe ? '0 : flt_q) | flt_new;
    end

    // Selects the register shown to a read.
    always_comb begin
        case (rd_addr)
            A_CFG:   rd_data = cfg_q;
            A_STAT:  rd_data = status_in;
            A_EVT:   rd_data = 8'(ev_q);
            A_IEN:   rd_data = 8'(ien_q);
            A_FLT:   rd_data = 8'(flt_q);
            A_WLEN:  rd_data = wlen_q;
            A_SCR:   rd_data = scr_q;
            default: rd_data = 8'h00;
        endcase
    end

    assign cfg_o  = cfg_q;
    assign wlen_o = wlen_q;
    assign irq_n  = ~|(ev_q & ien_q) & remote_irq_n;

    // R12: the stored word length always lies in the supported range.
    p_wlen_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wlen_q >= 8'(WLEN_MIN)) && (wlen_q <= 8'(WLEN_MAX)));

    // R6: a rejected write frame raises fault bit 0 and the fault event.
    p_wfault_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fault |=> flt_q[0] && ev_q[EV_FLT]);

    // R10: a fault bit stays set until the fault event is cleared.
    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q[0] && !flt_wipe) |=> flt_q[0]);

    // R11: a low remote interrupt always reaches the output.
    p_irq_remote_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !remote_irq_n |-> !irq_n);

endmodule

// File: rtl/regp_spi_regport.sv
// Module regp_spi_regport
// Top of the CRC-protected SPI register port. It synchronises the pins and
// connects the serial engine to the register file.
// Assumes SCK is much slower than clk.
module regp_spi_regport
    import regp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NX          = 4,
    parameter int WLEN_MIN    = 8,
    parameter int WLEN_MAX    = 32,
    parameter int WLEN_RST    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_csn,
    input  logic          spi_mosi,
    output logic          spi_miso,
    input  logic [7:0]    status_in,
    input  logic          link_up_pulse,
    input  logic          link_down_pulse,
    input  logic [NX-1:0] fault_pulse,
    input  logic          remote_irq_n,
    output logic [7:0]    cfg_o,
    output logic [7:0]    word_len_o,
    output logic          irq_n
);
    logic [2:0] pins_s;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    wr_req_t    wr_req;
    logic       wr_fault;

    regp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_csn, spi_sck, spi_mosi}),
        .q     (pins_s)
    );

    regp_spi_engine u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .csn_s    (pins_s[2]),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .miso     (spi_miso),
        .wr_req   (wr_req),
        .wr_fault (wr_fault)
    );

    regp_regfile #(
        .NX(NX), .WLEN_MIN(WLEN_MIN), .WLEN_MAX(WLEN_MAX), .WLEN_RST(WLEN_RST)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req),
        .wr_fault     (wr_fault),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .status_in    (status_in),
        .link_up      (link_up_pulse),
        .link_down    (link_down_pulse),
        .ext_flt      (fault_pulse),
        .remote_irq_n (remote_irq_n),
        .cfg_o        (cfg_o),
        .wlen_o       (word_len_o),
        .irq_n        (irq_n)
    );
endmodule

// File: tb/tb_regp_spi_regport.sv
module tb_regp_spi_regport;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic       spi_miso;
    logic [7:0] status_in = 8'h00;
    logic       link_up_pulse = 1'b0, link_down_pulse = 1'b0;
    logic [3:0] fault_pulse = '0;
    logic       remote_irq_n = 1'b1;
    logic [7:0] cfg_o, word_len_o;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;

    regp_spi_regport dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .status_in(status_in),
        .link_up_pulse(link_up_pulse), .link_down_pulse(link_down_pulse),
        .fault_pulse(fault_pulse), .remote_irq_n(remote_irq_n),
        .cfg_o(cfg_o), .word_len_o(word_len_o), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector fields: [24] mode (1,1), [23:17] address, [16] add CRC,
    // [15:8] data written, [7:0] value expected on read-back.
    localparam logic [24:0] VEC [10] = '{
        {1'b0, 7'h00, 1'b0, 8'hA5, 8'hA5},   // R4 config
        {1'b1, 7'h06, 1'b1, 8'h3C, 8'h3C},   // R5 scratch with CRC, mode (1,1)
        {1'b0, 7'h05, 1'b0, 8'h10, 8'h10},   // R12 in range
        {1'b1, 7'h05, 1'b1, 8'h02, 8'h08},   // R12 clamp low
        {1'b0, 7'h05, 1'b1, 8'hFF, 8'h20},   // R12 clamp high
        {1'b1, 7'h05, 1'b0, 8'h20, 8'h20},   // R12 upper edge
        {1'b0, 7'h03, 1'b0, 8'hFF, 8'h07},   // enables keep 3 bits
        {1'b1, 7'h7F, 1'b1, 8'h55, 8'h00},   // R8 unmapped
        {1'b0, 7'h04, 1'b0, 8'h1F, 8'h00},   // R8 read-only faults
        {1'b1, 7'h00, 1'b1, 8'h5A, 8'h5A}    // R5 config with CRC
    };

    // Computes the reference CRC-8 as the remainder of a polynomial division.
    function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] b);
        logic [23:0] m;
        m = {a, b, 8'h00};
        for (int i = 23; i >= 8; i--)
            if (m[i]) m[i -: 9] = m[i -: 9] ^ 9'h107;
        return m[7:0];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one SPI frame of nb bytes, or stops after cut bits when cut >= 0.
    task automatic spi_xfer(input bit m11, input int nb, input int cut,
                            input logic [7:0] t0, input logic [7:0] t1, input logic [7:0] t2,
                            output logic [7:0] q0, output logic [7:0] q1, output logic [7:0] q2);
        logic [23:0] tx, rx;
        int total;
        tx = {t0, t1, t2};
        rx = '0;
        total = (cut >= 0) ? cut : nb * 8;
        spi_sck = m11;
        wait_clk(HP);
        spi_csn = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < total; i++) begin
            if (m11) spi_sck = 1'b0;
            spi_mosi = tx[23-i];
            wait_clk(HP);
            rx[23-i] = spi_miso;
            spi_sck = 1'b1;
            wait_clk(HP);
            if (!m11) spi_sck = 1'b0;
        end
        wait_clk(HP);
        spi_csn = 1'b1;
        wait_clk(12);
        q0 = rx[23:16];
        q1 = rx[15:8];
        q2 = rx[7:0];
    endtask

    task automatic wr(input bit m11, input logic [6:0] a, input logic [7:0] d, input bit crc_on);
        logic [7:0] q0, q1, q2, c;
        c = ref_crc({a, 1'b0}, d);
        spi_xfer(m11, crc_on ? 3 : 2, -1, {a, 1'b0}, d, c, q0, q1, q2);
    endtask

    task automatic rd(input bit m11, input logic [6:0] a, output logic [7:0] d, output logic [7:0] c);
        logic [7:0] q0;
        spi_xfer(m11, 3, -1, {a, 1'b1}, 8'h00, 8'h00, q0, d, c);
    endtask

    // Reads a register and checks both its value and the read CRC.
    task automatic rd_chk(input string tag, input bit m11, input logic [6:0] a, input logic [7:0] exp);
        logic [7:0] d, c;
        rd(m11, a, d, c);
        chk(tag, {24'h0, d}, {24'h0, exp});
        chk({tag, " R7 crc"}, {24'h0, c}, {24'h0, ref_crc({a, 1'b1}, exp)});
    endtask

    initial begin : watchdog
        wait_clk(150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] q0, q1, q2;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        chk("R1 cfg_o", {24'h0, cfg_o}, 32'h00);
        chk("R1 word_len_o", {24'h0, word_len_o}, 32'h08);
        chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
        rd_chk("R1 scratch", 1'b0, 7'h06, 8'h00);
        rd_chk("R1 events", 1'b1, 7'h02, 8'h00);
        rd_chk("R1 faults", 1'b0, 7'h04, 8'h00);

        // R2 R3 R4 R5 R8 R12: write then read back, both modes
        for (int k = 0; k < 10; k++) begin
            wr(VEC[k][24], VEC[k][23:17], VEC[k][15:8], VEC[k][16]);
            rd_chk("R2 R3 R4 R5 table", VEC[k][24], VEC[k][23:17], VEC[k][7:0]);
        end
        chk("R4 cfg_o port", {24'h0, cfg_o}, 32'h5A);
        chk("R12 word_len_o port", {24'h0, word_len_o}, 32'h20);
        rd_chk("R6 no fault from valid frames", 1'b0, 7'h04, 8'h00);

        // R8: status follows the input and ignores writes
        status_in = 8'hC3;
        rd_chk("R8 status", 1'b0, 7'h01, 8'hC3);
        wr(1'b0, 7'h01, 8'h00, 1'b0);
        rd_chk("R8 status after write", 1'b1, 7'h01, 8'hC3);

        wr(1'b0, 7'h03, 8'h00, 1'b0);

        // R6: wrong CRC is discarded and flagged
        spi_xfer(1'b0, 3, -1, {7'h06, 1'b0}, 8'h99, ref_crc({7'h06, 1'b0}, 8'h99) ^ 8'hFF, q0, q1, q2);
        rd_chk("R6 bad crc scratch kept", 1'b0, 7'h06, 8'h3C);
        rd_chk("R6 bad crc fault", 1'b0, 7'h04, 8'h01);
        rd_chk("R6 bad crc event", 1'b0, 7'h02, 8'h04);

        // R10: clearing the fault event clears faults
        wr(1'b0, 7'h02, 8'h03, 1'b0);
        rd_chk("R10 faults wiped", 1'b0, 7'h04, 8'h00);
        rd_chk("R10 events cleared", 1'b0, 7'h02, 8'h00);

        // R6: frame ending after the command byte
        spi_xfer(1'b0, 1, -1, {7'h06, 1'b0}, 8'h00, 8'h00, q0, q1, q2);
        rd_chk("R6 truncated fault", 1'b0, 7'h04, 8'h01);
        wr(1'b0, 7'h02, 8'h00, 1'b0);

        // R6: frame ending in the middle of the data byte
        spi_xfer(1'b1, 2, 12, {7'h06, 1'b0}, 8'h77, 8'h00, q0, q1, q2);
        rd_chk("R6 mid-byte scratch kept", 1'b0, 7'h06, 8'h3C);
        rd_chk("R6 mid-byte fault", 1'b0, 7'h04, 8'h01);
        wr(1'b0, 7'h02, 8'h00, 1'b0);

        // R6: frame longer than three bytes
        spi_xfer(1'b0, 3, 28, {7'h06, 1'b0}, 8'h11, ref_crc({7'h06, 1'b0}, 8'h11), q0, q1, q2);
        rd_chk("R6 overlong scratch kept", 1'b0, 7'h06, 8'h3C);
        wr(1'b0, 7'h02, 8'h00, 1'b0);

        // R6: aborted read has no effect
        spi_xfer(1'b0, 3, 12, {7'h06, 1'b1}, 8'h00, 8'h00, q0, q1, q2);
        rd_chk("R6 aborted read no fault", 1'b0, 7'h04, 8'h00);

        // R9: link events, write-zero-to-clear
        @(negedge clk) link_up_pulse = 1'b1;
        @(negedge clk) begin link_up_pulse = 1'b0; link_down_pulse = 1'b1; end
        @(negedge clk) link_down_pulse = 1'b0;
        rd_chk("R9 events set", 1'b0, 7'h02, 8'h03);
        wr(1'b0, 7'h02, 8'h06, 1'b0);
        rd_chk("R9 bit0 cleared bit1 kept", 1'b1, 7'h02, 8'h02);
        chk("R11 masked irq", {31'h0, irq_n}, 32'h1);

        // R11: enable and remote AND
        wr(1'b0, 7'h03, 8'h02, 1'b0);
        chk("R11 enabled event irq", {31'h0, irq_n}, 32'h0);
        wr(1'b0, 7'h02, 8'h00, 1'b0);
        chk("R11 event cleared irq", {31'h0, irq_n}, 32'h1);
        remote_irq_n = 1'b0;
        wait_clk(2);
        chk("R11 remote low", {31'h0, irq_n}, 32'h0);
        remote_irq_n = 1'b1;
        wait_clk(2);
        chk("R11 remote high", {31'h0, irq_n}, 32'h1);

        // R10: external fault pulse
        @(negedge clk) fault_pulse = 4'b0100;
        @(negedge clk) fault_pulse = 4'b0000;
        rd_chk("R10 ext fault bit3", 1'b0, 7'h04, 8'h08);
        rd_chk("R10 fault event", 1'b0, 7'h02, 8'h04);
        wr(1'b0, 7'h03, 8'h04, 1'b0);
        chk("R11 fault event irq", {31'h0, irq_n}, 32'h0);
        wr(1'b0, 7'h02, 8'h00, 1'b0);
        rd_chk("R10 ext fault wiped", 1'b0, 7'h04, 8'h00);
        chk("R11 irq released", {31'h0, irq_n}, 32'h1);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule